// File: doc/BRIEF.md
# Escape Sequence Classifier

This block receives an 8N1 asynchronous serial line and groups the incoming bytes into keyboard items. A byte that arrives on its own is a plain key. A byte of value 0x1B opens an escape sequence: a keyboard sends the bytes of one multi-byte key code with no idle time between them. Two separate keypresses, however, can arrive with an idle gap shorter than one character time. The block therefore decides which bytes belong together by timing that gap in hardware. It does not look at byte content past the opening 0x1B, and it does not use a long FIFO timeout. Software latency plays no part in the grouping.

The receiver oversamples the line at 16 ticks per bit, and the tick rate is set by a clock divider parameter. After each byte's stop bit, a gap counter counts idle ticks. If the line stays idle for more than `gapThresh` ticks past the end of the stop bit, the pending sequence is closed. A suitable setting at 115200 baud is 4 ticks, a quarter of a bit. Finished items appear on a valid/ready output that carries up to four bytes, a length and an error bit. A sticky flag records any item that was lost because the output was stalled.

Top module: `escSeqClassifier`

## Requirements
- R1: After reset, `itemValid` and `overflow` are low, and the receiver waits for a start bit.
- R2: Each byte is received as one low start bit, 8 data bits with the least significant bit first, and one high stop bit. One bit lasts 16 ticks, and one tick lasts TICK_DIV clocks.
- R3: A byte other than 0x1B that completes while no sequence is open is emitted at once, with length 1, error 0 and the byte in bits [7:0].
- R4: The idle gap runs from the end of a stop bit to the next start bit. A byte that follows an open sequence with a gap of at most `gapThresh` ticks joins that sequence. A gap wider than that closes the sequence first.
- R5: When 0x1B and two following bytes are closed by a gap or by idle line, they are emitted with length 3 and error 0.
- R6: When a fourth contiguous byte completes, the sequence is emitted at once with length 4. The byte after it starts a new item.
- R7: When 0x1B is followed by a gap, it is emitted alone with length 1 and error 0.
- R8: When 0x1B and exactly one more byte are followed by a gap, both bytes are emitted with length 2 and error 1.
- R9: `gapThresh` sets the threshold in ticks. With a larger value, gaps that would otherwise split items count as contiguous.
- R10: Byte k of an item sits in bits [8k+7:8k], and slots beyond the length read zero. While `itemValid` is high and `itemReady` is low, all item outputs hold steady.
- R11: An item that completes while the output is stalled is dropped, the held item stays unchanged, and `overflow` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLine | input | 1 | Serial receive line, idle high |
| gapThresh | input | THRESH_W | Idle gap threshold in oversample ticks |
| itemReady | input | 1 | Consumer accepts the current item |
| itemValid | output | 1 | An item is presented |
| itemBytes | output | 32 | Item bytes, byte 0 in the low bits |
| itemLen | output | 3 | Item length, 1 to 4 |
| itemErr | output | 1 | Sequence was cut short after two bytes |
| overflow | output | 1 | Sticky flag: an item was dropped |

## Verification
The hardest cases to reach are the ones where the gap is shorter than a full character but still wider than the threshold. In these cases a lone 0x1B, or 0x1B with one byte, must close before the next byte arrives. The driver places stop and start bits on exact tick multiples, so a back-to-back byte and a two-bit gap differ from each other by a known number of ticks. The same two-bit gap is then replayed with a raised threshold to show that it becomes contiguous. Overflow is reached by holding `itemReady` low across two separate keys and then checking which item survives.

// File: rtl/escSeqPkg.sv
package escSeqPkg;
  localparam int BYTE_W = 8;
  localparam int MAX_BYTES = 4;
  localparam int LEN_W = 3;
  localparam logic [BYTE_W-1:0] ESC_CODE = 8'h1B;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxStateT;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_TWO, SEQ_THREE} seqStateT;

  // strobes from control to the sequence datapath
  typedef struct packed {
    logic       store;   // write current received byte into slot
    logic [1:0] slot;
    logic       emit;    // close item (including a same-cycle store)
    logic [LEN_W-1:0] len;
    logic       err;
  } seqStrobeT;
endpackage

// File: rtl/escUartRx.sv
module escUartRx
  import escSeqPkg::*;
#(
  parameter int TICK_DIV   = 68,
  parameter int OVERSAMPLE = 16,
  parameter int THRESH_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxLine,
  input  logic [THRESH_W-1:0] gapThresh,
  output logic                byteDone,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                gapHit
);
  localparam int DIV_W     = $clog2(TICK_DIV + 1);
  localparam int OS_W      = $clog2(OVERSAMPLE);
  localparam int HALF      = OVERSAMPLE / 2;
  localparam int GAP_W     = THRESH_W + 1;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  logic [1:0]           syncQ;
  logic                 rxS;
  logic [DIV_W-1:0]     divCnt;
  logic                 tick;
  rxStateT              state;
  logic [OS_W-1:0]      osCnt;
  logic [BIT_IDX_W-1:0] bitIdx;
  logic [BYTE_W-1:0]    shiftQ;
  logic [GAP_W-1:0]     gapCnt;
  logic [GAP_W-1:0]     gapLimit;

  assign rxS      = syncQ[1];
  assign tick     = (divCnt == DIV_W'(TICK_DIV - 1));
  // gap counted from the mid-stop sample; half a bit remains of the stop bit
  assign gapLimit = GAP_W'(gapThresh) + GAP_W'(HALF);
  assign rxByte   = shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      divCnt <= '0;
    end else begin
      syncQ  <= {syncQ[0], rxLine};
      divCnt <= tick ? '0 : divCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      osCnt    <= '0;
      bitIdx   <= '0;
      shiftQ   <= '0;
      gapCnt   <= '1;
      byteDone <= 1'b0;
      gapHit   <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      gapHit   <= 1'b0;
      if (tick) begin
        if (state == RX_IDLE && rxS && gapCnt != '1) begin
          gapCnt <= gapCnt + GAP_W'(1);
          gapHit <= ((gapCnt + GAP_W'(1)) == gapLimit);
        end
        case (state)
          RX_IDLE: begin
            if (!rxS) begin
              state <= RX_START;
              osCnt <= '0;
            end
          end
          RX_START: begin
            if (osCnt == OS_W'(HALF - 1)) begin
              osCnt  <= '0;
              bitIdx <= '0;
              state  <= rxS ? RX_IDLE : RX_DATA;
            end else begin
              osCnt <= osCnt + OS_W'(1);
            end
          end
          RX_DATA: begin
            if (osCnt == OS_W'(OVERSAMPLE - 1)) begin
              osCnt  <= '0;
              shiftQ <= {rxS, shiftQ[BYTE_W-1:1]};
              if (bitIdx == BIT_IDX_W'(BYTE_W - 1)) state <= RX_STOP;
              else bitIdx <= bitIdx + BIT_IDX_W'(1);
            end else begin
              osCnt <= osCnt + OS_W'(1);
            end
          end
          RX_STOP: begin
            if (osCnt == OS_W'(OVERSAMPLE - 1)) begin
              osCnt    <= '0;
              state    <= RX_IDLE;
              gapCnt   <= '0;
              byteDone <= rxS;
            end else begin
              osCnt <= osCnt + OS_W'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assert_done_gap_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> !gapHit);
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> $past(rxS));
  assert_gap_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> (gapCnt == '0));
endmodule

// File: rtl/escSeqCtrl.sv
module escSeqCtrl
  import escSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              gapHit,
  output seqStrobeT         strobe
);
  seqStateT state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      SEQ_IDLE: begin
        if (byteDone) begin
          strobe.store = 1'b1;
          strobe.slot  = 2'd0;
          if (rxByte == ESC_CODE) begin
            stateNext = SEQ_ONE;
          end else begin
            strobe.emit = 1'b1;
            strobe.len  = LEN_W'(1);
          end
        end
      end
      SEQ_ONE: begin
        if (byteDone) begin
          strobe.store = 1'b1;
          strobe.slot  = 2'd1;
          stateNext    = SEQ_TWO;
        end else if (gapHit) begin
          strobe.emit = 1'b1;
          strobe.len  = LEN_W'(1);
          stateNext   = SEQ_IDLE;
        end
      end
      SEQ_TWO: begin
        if (byteDone) begin
          strobe.store = 1'b1;
          strobe.slot  = 2'd2;
          stateNext    = SEQ_THREE;
        end else if (gapHit) begin
          strobe.emit = 1'b1;
          strobe.len  = LEN_W'(2);
          strobe.err  = 1'b1;
          stateNext   = SEQ_IDLE;
        end
      end
      SEQ_THREE: begin
        if (byteDone) begin
          strobe.store = 1'b1;
          strobe.slot  = 2'd3;
          strobe.emit  = 1'b1;
          strobe.len   = LEN_W'(4);
          stateNext    = SEQ_IDLE;
        end else if (gapHit) begin
          strobe.emit = 1'b1;
          strobe.len  = LEN_W'(3);
          stateNext   = SEQ_IDLE;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assert_gap_closes_R5: assert property (@(posedge clk) disable iff (!rstN)
    gapHit |=> (state == SEQ_IDLE));
  assert_fourth_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_THREE && byteDone) |=> (state == SEQ_IDLE));
  assert_open_on_escape_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && byteDone && rxByte == ESC_CODE) |=> (state == SEQ_ONE));
endmodule

// File: rtl/escSeqData.sv
module escSeqData
  import escSeqPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobeT                   strobe,
  input  logic [BYTE_W-1:0]           rxByte,
  input  logic                        itemReady,
  output logic                        itemValid,
  output logic [MAX_BYTES*BYTE_W-1:0] itemBytes,
  output logic [LEN_W-1:0]            itemLen,
  output logic                        itemErr,
  output logic                        overflow
);
  logic [MAX_BYTES-1:0][BYTE_W-1:0] bufQ, merged, masked;

  genvar gi;
  generate
    for (gi = 0; gi < MAX_BYTES; gi++) begin : gSlot
      assign merged[gi] = (strobe.store && strobe.slot == 2'(gi)) ? rxByte : bufQ[gi];
      assign masked[gi] = (LEN_W'(gi) < strobe.len) ? merged[gi] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufQ      <= '0;
      itemValid <= 1'b0;
      itemBytes <= '0;
      itemLen   <= '0;
      itemErr   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (itemValid && itemReady) itemValid <= 1'b0;
      if (strobe.emit) begin
        bufQ <= '0;
        if (itemValid && !itemReady) begin
          overflow <= 1'b1;
        end else begin
          itemValid <= 1'b1;
          itemBytes <= masked;
          itemLen   <= strobe.len;
          itemErr   <= strobe.err;
        end
      end else if (strobe.store) begin
        bufQ <= merged;
      end
    end
  end

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (itemValid && !itemReady) |=> (itemValid && $stable(itemBytes) && $stable(itemLen) && $stable(itemErr)));
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  assert_len_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    itemValid |-> (itemLen >= LEN_W'(1) && itemLen <= LEN_W'(MAX_BYTES)));
  assert_err_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    (itemValid && itemErr) |-> (itemLen == LEN_W'(2)));
  assert_single_upper_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (itemValid && itemLen == LEN_W'(1)) |-> (itemBytes[MAX_BYTES*BYTE_W-1:BYTE_W] == '0));
  assert_multi_head_R4: assert property (@(posedge clk) disable iff (!rstN)
    (itemValid && itemLen > LEN_W'(1)) |-> (itemBytes[BYTE_W-1:0] == ESC_CODE));
endmodule

// File: rtl/escSeqClassifier.sv
module escSeqClassifier
  import escSeqPkg::*;
#(
  parameter int TICK_DIV   = 68,
  parameter int OVERSAMPLE = 16,
  parameter int THRESH_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxLine,
  input  logic [THRESH_W-1:0]         gapThresh,
  input  logic                        itemReady,
  output logic                        itemValid,
  output logic [MAX_BYTES*BYTE_W-1:0] itemBytes,
  output logic [LEN_W-1:0]            itemLen,
  output logic                        itemErr,
  output logic                        overflow
);
  logic              byteDone;
  logic              gapHit;
  logic [BYTE_W-1:0] rxByte;
  seqStrobeT         strobe;

  escUartRx #(
    .TICK_DIV(TICK_DIV), .OVERSAMPLE(OVERSAMPLE), .THRESH_W(THRESH_W)
  ) uRx (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .gapThresh(gapThresh),
    .byteDone(byteDone), .rxByte(rxByte), .gapHit(gapHit)
  );

  escSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .rxByte(rxByte),
    .gapHit(gapHit), .strobe(strobe)
  );

  escSeqData uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .itemReady(itemReady), .itemValid(itemValid), .itemBytes(itemBytes),
    .itemLen(itemLen), .itemErr(itemErr), .overflow(overflow)
  );
endmodule

// File: tb/tb_escSeqClassifier.sv
module tb_escSeqClassifier;
  localparam int TICK_DIV = 2;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic [7:0]  gapThresh = 8'd4;
  logic        itemReady = 1'b0;
  logic        itemValid;
  logic [31:0] itemBytes;
  logic [2:0]  itemLen;
  logic        itemErr;
  logic        overflow;

  always #4 clk = ~clk;

  escSeqClassifier #(.TICK_DIV(TICK_DIV), .OVERSAMPLE(16), .THRESH_W(8)) dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .gapThresh(gapThresh),
    .itemReady(itemReady), .itemValid(itemValid), .itemBytes(itemBytes),
    .itemLen(itemLen), .itemErr(itemErr), .overflow(overflow)
  );

  typedef struct packed { logic [2:0] len; logic err; logic [31:0] bytes; } itemT;
  itemT  expQ[$];
  string tagQ[$];
  int checks = 0;
  int failures = 0;
  bit ended = 0;

  task automatic checkVal(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expectItem(string tag, int len, bit err, logic [7:0] b0, logic [7:0] b1,
                            logic [7:0] b2, logic [7:0] b3);
    itemT e;
    e.len = 3'(len);
    e.err = err;
    e.bytes = {b3, b2, b1, b0};
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // called while aligned to a falling clock edge
  task automatic sendByte(logic [7:0] b, int gapTicks);
    rxLine = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (BIT_CLKS + gapTicks * TICK_DIV) @(negedge clk);
  endtask

  task automatic settle(string tag);
    repeat (400) @(negedge clk);
    checkVal(tag, "pending expected items", expQ.size(), 0);
  endtask

  task automatic setReady(logic v);
    @(posedge clk);
    #1 itemReady = v;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && itemValid && itemReady) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R3 unexpected item actual=%0h len=%0d expected=none", itemBytes, itemLen);
      end else begin
        itemT  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkVal(t, "item {len,err,bytes}", {itemLen, itemErr, itemBytes}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    checkVal("R1", "itemValid in reset", itemValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkVal("R1", "itemValid after reset", itemValid, 0);
    checkVal("R1", "overflow after reset", overflow, 0);
    setReady(1'b1);

    // plain key, asymmetric bit pattern checks bit order
    expectItem("R2/R3", 1, 0, 8'h61, 8'h00, 8'h00, 8'h00);
    sendByte(8'h61, 0);
    settle("R3");

    expectItem("R5", 3, 0, 8'h1B, 8'h5B, 8'h41, 8'h00);
    sendByte(8'h1B, 0); sendByte(8'h5B, 0); sendByte(8'h41, 0);
    settle("R5");

    expectItem("R6", 4, 0, 8'h1B, 8'h5B, 8'h31, 8'h7E);
    sendByte(8'h1B, 0); sendByte(8'h5B, 0); sendByte(8'h31, 0); sendByte(8'h7E, 0);
    settle("R6");

    // fifth contiguous byte starts a fresh item
    expectItem("R6", 4, 0, 8'h1B, 8'h5B, 8'h32, 8'h7E);
    expectItem("R6", 1, 0, 8'h62, 8'h00, 8'h00, 8'h00);
    sendByte(8'h1B, 0); sendByte(8'h5B, 0); sendByte(8'h32, 0); sendByte(8'h7E, 0);
    sendByte(8'h62, 0);
    settle("R6");

    expectItem("R7", 1, 0, 8'h1B, 8'h00, 8'h00, 8'h00);
    sendByte(8'h1B, 0);
    settle("R7");

    expectItem("R8", 2, 1, 8'h1B, 8'h4F, 8'h00, 8'h00);
    sendByte(8'h1B, 0); sendByte(8'h4F, 0);
    settle("R8");

    // gap of two bits (well under one character) splits the bytes
    expectItem("R4/R7", 1, 0, 8'h1B, 8'h00, 8'h00, 8'h00);
    expectItem("R4", 1, 0, 8'h5B, 8'h00, 8'h00, 8'h00);
    expectItem("R4", 1, 0, 8'h41, 8'h00, 8'h00, 8'h00);
    sendByte(8'h1B, 32); sendByte(8'h5B, 0); sendByte(8'h41, 0);
    settle("R4");

    expectItem("R8", 2, 1, 8'h1B, 8'h5B, 8'h00, 8'h00);
    expectItem("R4", 1, 0, 8'h43, 8'h00, 8'h00, 8'h00);
    sendByte(8'h1B, 0); sendByte(8'h5B, 32); sendByte(8'h43, 0);
    settle("R8");

    // raised threshold makes the same two-bit gaps contiguous
    gapThresh = 8'd40;
    expectItem("R9", 3, 0, 8'h1B, 8'h5B, 8'h44, 8'h00);
    sendByte(8'h1B, 32); sendByte(8'h5B, 32); sendByte(8'h44, 0);
    settle("R9");
    gapThresh = 8'd4;

    // stall: first item held, second dropped
    setReady(1'b0);
    expectItem("R11", 1, 0, 8'h71, 8'h00, 8'h00, 8'h00);
    sendByte(8'h71, 40);
    repeat (50) @(negedge clk);
    checkVal("R10", "itemValid held under stall", itemValid, 1);
    checkVal("R11", "overflow before drop", overflow, 0);
    sendByte(8'h72, 40);
    repeat (50) @(negedge clk);
    checkVal("R11", "overflow after drop", overflow, 1);
    checkVal("R10", "held bytes unchanged", itemBytes, 32'h71);
    checkVal("R10", "held len unchanged", itemLen, 1);
    setReady(1'b1);
    settle("R11");
    checkVal("R11", "overflow sticky", overflow, 1);
    checkVal("R10", "itemValid after accept", itemValid, 0);

    finishRun();
  end
endmodule